// File: doc/BRIEF.md
# Scan Velocity Modulation Processor

This block turns a luminance sample stream into a signed drive value for a scan velocity modulation coil. Each accepted pixel is differentiated against an earlier pixel at a programmable distance. The difference then goes through a coring dead zone, a gain and a symmetric saturating limiter. The limited value then enters an alignment delay line. The position in that line is set in half-sample steps, so that the drive signal can be matched to the timing of the colour output path.

The block holds two coefficient sets, one for normal video and one for text. Each set has a 6-bit gain and a 3-bit differentiator distance. A mode input is sampled together with every pixel, so on-screen text regions can switch to the text set for single pixels. The coring threshold, the limit and the alignment value are shared by both sets. The reset values are gain 60, distance 4, limit 100, coring 0 and alignment 5. The block applies no defaults of its own: it uses whatever values are on the field inputs.

Top module: `svm_proc`

## Requirements
- R1: After reset, every stored sample and result is zero and `svm_o` reads 0.
- R2: For a sample x[n] accepted with `valid_i` high, the difference is x[n] − x[n−d]. Here d (1 to 6) is the selected distance field, and samples from before reset count as 0.
- R3: A selected distance code of 0 or 7 switches the differentiator off, and that sample's result is 0.
- R4: `text_mode_i` is sampled with each accepted pixel. When it is 1, the gain and distance come from `txt_gain_i`/`txt_dly_i`; when it is 0, they come from `vid_gain_i`/`vid_dly_i`.
- R5: Coring: a difference whose magnitude is at or below `core_i` becomes 0. A larger magnitude is reduced by `core_i` and keeps its sign.
- R6: Gain: the cored value c becomes floor(c × g / 16), where g is the selected unsigned gain.
- R7: Limiter: the scaled value is saturated to the range −`limit_i` to +`limit_i`.
- R8: Alignment A = `align_i` picks from the results of accepted samples. For even A, `svm_o` is the result produced A/2 accepted samples before the newest one. For odd A, it is the floor of the mean of the results (A−1)/2 and (A+1)/2 samples back. With A = 0, the result of a sample appears on the first clock edge that accepts it.
- R9: While `valid_i` is low, no state changes, and `svm_o` holds as long as `align_i` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Pixel strobe; the sample and mode are taken when high |
| y_i | input | 8 | Unsigned luminance sample |
| text_mode_i | input | 1 | Selects the text coefficient set for this pixel |
| vid_gain_i | input | 6 | Video-mode gain in 1/16 steps |
| vid_dly_i | input | 3 | Video-mode differentiator distance (0 = off) |
| txt_gain_i | input | 6 | Text-mode gain in 1/16 steps |
| txt_dly_i | input | 3 | Text-mode differentiator distance (0 = off) |
| limit_i | input | 7 | Symmetric output limit |
| core_i | input | 4 | Coring threshold |
| align_i | input | 4 | Output alignment in half-sample steps |
| svm_o | output | 8 | Signed modulation drive value |

## Verification
Every distance code is swept against every alignment value. The gain, coring threshold and limit change from one configuration to the next, so the sweep also covers a zero gain, large thresholds and tight limits. Three luminance patterns are used for each configuration:
- A stepped ramp gives evenly spaced differences, which separates the distances from each other.
- Hard black/white edges give full-scale differences of both signs, which exercises the limiter and the floor rounding of negative values.
- A pseudo-random sequence shows up wrong history taps and wrong averaging pairs.

Some configurations toggle the mode on every pixel and give the text set a different distance, which shows whether the coefficients really follow each pixel. Idle cycles with changing inputs check that nothing moves without the strobe.

// File: rtl/svm_proc.sv
module svm_proc #(
  parameter int YW   = 8,
  parameter int GW   = 6,
  parameter int DW   = 3,
  parameter int LW   = 7,
  parameter int CW   = 4,
  parameter int AW   = 4,
  parameter int MAXD = 6,
  parameter int SH   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 valid_i,
  input  logic [YW-1:0]        y_i,
  input  logic                 text_mode_i,
  input  logic [GW-1:0]        vid_gain_i,
  input  logic [DW-1:0]        vid_dly_i,
  input  logic [GW-1:0]        txt_gain_i,
  input  logic [DW-1:0]        txt_dly_i,
  input  logic [LW-1:0]        limit_i,
  input  logic [CW-1:0]        core_i,
  input  logic [AW-1:0]        align_i,
  output logic signed [LW:0]   svm_o
);
  localparam int XW = YW + 1;
  localparam int PW = XW + GW + 1;
  localparam int OW = LW + 1;
  localparam int LN = (1 << AW) / 2 + 1;

  logic [YW-1:0]        hist [MAXD];
  logic signed [OW-1:0] line [LN];

  wire [DW-1:0] dsel = text_mode_i ? txt_dly_i : vid_dly_i;
  wire [GW-1:0] gsel = text_mode_i ? txt_gain_i : vid_gain_i;
  wire          on   = (dsel != '0) && (int'(dsel) <= MAXD);

  logic [YW-1:0] past;
  always_comb begin
    past = '0;
    for (int k = 0; k < MAXD; k++)
      if (int'(dsel) == k + 1) past = hist[k];
  end

  wire signed [XW-1:0] diff  = on ? ($signed({1'b0, y_i}) - $signed({1'b0, past})) : '0;
  wire        [XW-1:0] mag   = diff[XW-1] ? -diff : diff;
  wire        [XW-1:0] corex = {{(XW-CW){1'b0}}, core_i};
  wire        [XW-1:0] magc  = (mag > corex) ? mag - corex : '0;
  wire signed [XW-1:0] cored = diff[XW-1] ? -$signed(magc) : $signed(magc);

  wire signed [PW-1:0] ce   = {{(PW-XW){cored[XW-1]}}, cored};
  wire signed [PW-1:0] ge   = {{(PW-GW){1'b0}}, gsel};
  wire signed [PW-1:0] prod = ce * ge;
  wire signed [PW-1:0] scl  = prod >>> SH;
  wire signed [PW-1:0] lim  = {{(PW-LW){1'b0}}, limit_i};
  wire signed [PW-1:0] sat  = (scl > lim) ? lim : ((scl < -lim) ? -lim : scl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < MAXD; k++) hist[k] <= '0;
      for (int k = 0; k < LN; k++)   line[k] <= '0;
    end else if (valid_i) begin
      hist[0] <= y_i;
      for (int k = 1; k < MAXD; k++) hist[k] <= hist[k-1];
      line[0] <= sat[OW-1:0];
      for (int k = 1; k < LN; k++)   line[k] <= line[k-1];
    end
  end

  logic signed [OW-1:0] tap_a, tap_b;
  always_comb begin
    tap_a = '0;
    tap_b = '0;
    for (int k = 0; k < LN - 1; k++)
      if (int'(align_i[AW-1:1]) == k) begin
        tap_a = line[k];
        tap_b = line[k+1];
      end
  end

  wire signed [OW:0] pair = {tap_a[OW-1], tap_a} + {tap_b[OW-1], tap_b};
  assign svm_o = align_i[0] ? pair[OW:1] : tap_a;

  AST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (line[0] <= $signed({1'b0, $past(limit_i)}) &&
                 line[0] >= -$signed({1'b0, $past(limit_i)}))); // R7
  AST_FILTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (text_mode_i ? txt_dly_i : vid_dly_i) == '0) |=> line[0] == '0); // R3
  AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && (text_mode_i ? txt_gain_i : vid_gain_i) == '0) |=> line[0] == '0); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && $stable(align_i)) |=> $stable(svm_o)); // R9
endmodule

// File: tb/test_svm_proc.sv
module test_svm_proc;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, valid_i = 0, text_mode_i = 0;
  logic [7:0] y_i = 0;
  logic [5:0] vid_gain_i = 60, txt_gain_i = 60;
  logic [2:0] vid_dly_i = 4, txt_dly_i = 4;
  logic [6:0] limit_i = 100;
  logic [3:0] core_i = 0, align_i = 5;
  logic signed [7:0] svm_o;

  int checks = 0, errors = 0;
  int ys [0:63];
  int cr [0:63];
  int n;

  always #(CLK_PERIOD/2) clk = ~clk;

  svm_proc i_svm_proc (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .y_i(y_i),
    .text_mode_i(text_mode_i), .vid_gain_i(vid_gain_i), .vid_dly_i(vid_dly_i),
    .txt_gain_i(txt_gain_i), .txt_dly_i(txt_dly_i), .limit_i(limit_i),
    .core_i(core_i), .align_i(align_i), .svm_o(svm_o));

  function automatic int model(int cur, int pst, bit on, int g, int c, int lim);
    int d, m, mc, cd, p;
    d  = on ? cur - pst : 0;
    m  = d < 0 ? -d : d;
    mc = m > c ? m - c : 0;
    cd = d < 0 ? -mc : mc;
    p  = (cd * g) >>> 4;
    if (p > lim) p = lim;
    if (p < -lim) p = -lim;
    return p;
  endfunction

  function automatic int expect_out(int last, int a);
    int i, x, y;
    i = a >> 1;
    x = (last - i >= 0) ? cr[last - i] : 0;
    y = (last - i - 1 >= 0) ? cr[last - i - 1] : 0;
    return (a % 2 == 1) ? ((x + y) >>> 1) : x;
  endfunction

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    valid_i = 0;
    @(negedge clk);
    rst_n = 1;
    n = 0;
  endtask

  task automatic feed(int y, bit mode, string req);
    int d, g, pst;
    bit on;
    d  = mode ? int'(txt_dly_i) : int'(vid_dly_i);
    g  = mode ? int'(txt_gain_i) : int'(vid_gain_i);
    on = d >= 1 && d <= 6;
    pst = (on && n - d >= 0) ? ys[n - d] : 0;
    ys[n] = y;
    cr[n] = model(y, pst, on, g, int'(core_i), int'(limit_i));
    y_i = 8'(y);
    text_mode_i = mode;
    valid_i = 1;
    @(negedge clk);
    valid_i = 0;
    check(int'(svm_o), expect_out(n, int'(align_i)), req);
    n++;
  endtask

  initial begin
    int lfsr;
    int held;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(int'(svm_o), 0, "R1 reset output");
    for (int dly = 0; dly < 8; dly++) begin
      for (int al = 0; al < 16; al++) begin
        for (int pat = 0; pat < 3; pat++) begin
          do_reset();
          vid_dly_i  = 3'(dly);
          txt_dly_i  = 3'((dly + 3) % 8);
          vid_gain_i = 6'((dly == 2 && al == 3) ? 0 : (dly * 9 + al * 5 + 60) % 64);
          txt_gain_i = 6'((dly * 5 + al * 11 + 7) % 64);
          core_i     = 4'((dly + al + pat) % 16);
          limit_i    = 7'(5 + (al * 7 + dly * 13 + pat * 29) % 123);
          align_i    = 4'(al);
          lfsr = 8'hA5 + dly + al;
          for (int i = 0; i < 20; i++) begin
            int y;
            bit mode;
            if (pat == 0) y = (i * 37) % 256;
            else if (pat == 1) y = ((i / 3) % 2) ? 255 : 0;
            else begin
              lfsr = ((lfsr << 1) | (((lfsr >> 7) ^ (lfsr >> 5) ^ (lfsr >> 4) ^ (lfsr >> 3)) & 1)) & 255;
              y = lfsr;
            end
            mode = (al % 2 == 1) ? (i % 2 == 1) : 1'b0;
            if (dly == 0 && !mode) feed(y, mode, "R3 filter off");
            else if (mode) feed(y, mode, "R4 text set R2 R5 R6 R7 R8");
            else feed(y, mode, "R2 R5 R6 R7 R8 video set");
          end
          held = int'(svm_o);
          y_i = 8'(~y_i);
          text_mode_i = ~text_mode_i;
          repeat (2) @(negedge clk);
          check(int'(svm_o), held, "R9 idle hold");
          feed(128, 1'b0, "R9 state unchanged after idle");
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule